// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block moves data out of a 16 KB sector buffer once software has set up a start address, a byte count and a destination code and then pulsed the trigger. Two kinds of destination exist. For a host read destination, the engine fetches one 16-bit word into an output latch and raises a data-ready flag. Each later host read strobe then fetches the next word. For a memory destination, the engine streams bytes to an external write port. The pace is fixed at a set number of clocks per byte, and bytes go out in groups of eight.

The byte counter is loaded with the length minus one. The transfer finishes when a decrement makes the counter negative. At that point the counter is parked at all ones, the busy and enable outputs return high, an active-low transfer-end flag drops, and the end flag is set. The transfer-end flag can raise an interrupt request, and it stays low until acknowledged. While the destination memory is owned by another master, a memory transfer waits without losing its place. Dropping output enable abandons the transfer.

Top module: `sbuf_xfer`

## Requirements
- R1: After reset, busy_no, xen_no and tend_no are 1, while end_o, data_rdy_o and irq_o are 0.
- R2: A trig_i pulse while out_en_i is 1 and no transfer is active drives busy_no and xen_no to 0 and clears end_o and data_rdy_o. A trig_i pulse while out_en_i is 0 starts nothing.
- R3: For dest codes 2 and 3, a fetch reads buffer byte {addr[13:1],0} into bits 15:8 of host_data_o and byte {addr[13:1],1} into bits 7:0. It then sets data_rdy_o, adds 2 to addr_o and subtracts 2 from cnt_o. The first fetch follows the trigger.
- R4: While end_o is 0, a host_rd_i strobe during a host transfer starts the next fetch. While end_o is 1, a strobe only clears data_rdy_o and leaves host_data_o unchanged.
- R5: A host_rd_i strobe that arrives while a fetch is in flight is held. It is acted on once the latch has been refilled.
- R6: When a decrement makes cnt_o negative (bit 15 set), cnt_o becomes 0xFFFF, busy_no and xen_no return to 1, tend_no goes to 0 and end_o is set. irq_o is 1 while tend_no is 0 and end_ie_i is 1. end_ack_i returns tend_no to 1.
- R7: For dest codes 4, 5 and 7, bytes are written on dma_wr_o in ascending buffer address order, with addr_o rising by 1 per byte. Each 8-byte group starts 128 clocks after the previous one (16 clocks per byte), and each full group subtracts 8 from cnt_o.
- R8: When a group is due and cnt_o is below 8, the engine writes cnt_o+1 bytes and the transfer ends as in R6.
- R9: While dst_owned_i is 1, a memory transfer neither advances its pacing nor writes bytes. It resumes when dst_owned_i returns to 0.
- R10: Dest codes 0, 1 and 6 start a transfer (busy_no and xen_no go to 0) that moves no data and never ends by itself.
- R11: Driving out_en_i to 0 during a transfer returns busy_no and xen_no to 1 without setting end_o, and no further bytes are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_en_i | input | 1 | Output enable; low aborts a transfer |
| dest_i | input | 3 | Destination code, sampled at trigger |
| dst_owned_i | input | 1 | Destination memory owned by another master |
| addr_ld_i | input | 1 | Load the data address counter |
| addr_val_i | input | 16 | Address load value |
| cnt_ld_i | input | 1 | Load the byte counter |
| cnt_val_i | input | 12 | Byte count minus one |
| trig_i | input | 1 | Start strobe |
| end_ack_i | input | 1 | Acknowledge the transfer-end flag |
| end_ie_i | input | 1 | Transfer-end interrupt enable |
| host_rd_i | input | 1 | Host read strobe |
| host_data_o | output | 16 | Host word latch |
| data_rdy_o | output | 1 | Latch holds a fresh word |
| end_o | output | 1 | Transfer finished |
| buf_rd_o | output | 1 | Buffer read enable |
| buf_addr_o | output | 14 | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after buf_rd_o |
| dma_wr_o | output | 1 | Destination byte write strobe |
| dma_data_o | output | 8 | Destination byte |
| dma_dest_o | output | 3 | Destination code of the running transfer |
| busy_no | output | 1 | Busy, active low |
| xen_no | output | 1 | Transfer enabled, active low |
| tend_no | output | 1 | Transfer-end flag, active low |
| irq_o | output | 1 | Transfer-end interrupt request |
| addr_o | output | 16 | Data address counter |
| cnt_o | output | 16 | Byte counter |

## Verification
Some properties are checked on every cycle: the start and abort responses of the enable outputs; the parked counter and the flag states at the moment end_o rises; that no byte is written while the destination is owned or no transfer is active; and that the host latch stays frozen once end_o is set. Other behaviours can only be shown by the directed scenarios: big-endian word order, the 14-bit buffer wrap, the held strobe replay, the 128-clock spacing between groups, the short final group, and the silent non-moving codes. Each of these needs a chosen setup and an expected value computed from the requirements.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  typedef enum logic [1:0] {H_IDLE, H_HI, H_LO, H_FILL} host_st_e;

  function automatic logic is_host(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd3);
  endfunction

  function automatic logic is_dma(input logic [2:0] code);
    return (code == 3'd4) || (code == 3'd5) || (code == 3'd7);
  endfunction
endpackage

// File: rtl/sbx_counters.sv
module sbx_counters #(
  parameter int CNT_W = 12,
  parameter int GROUP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_ld_i,
  input  logic [15:0]      addr_val_i,
  input  logic             cnt_ld_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             word_step_i,
  input  logic             byte_step_i,
  input  logic             grp_debit_i,
  input  logic             force_end_i,
  output logic [15:0]      addr_o,
  output logic [15:0]      cnt_o,
  output logic             word_last_o
);
  localparam logic [15:0] GROUP_W = 16'(GROUP);

  logic [15:0] addr_q, cnt_q, cnt_dec2;

  assign cnt_dec2    = cnt_q - 16'd2;
  assign word_last_o = cnt_dec2[15];
  assign addr_o      = addr_q;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (addr_ld_i) begin
      addr_q <= addr_val_i;
    end else if (word_step_i) begin
      addr_q <= addr_q + 16'd2;
    end else if (byte_step_i) begin
      addr_q <= addr_q + 16'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (force_end_i) begin
      cnt_q <= 16'hFFFF;
    end else if (cnt_ld_i) begin
      cnt_q <= 16'(cnt_val_i);
    end else if (word_step_i) begin
      cnt_q <= cnt_dec2;
    end else if (grp_debit_i) begin
      cnt_q <= cnt_q - GROUP_W;
    end
  end
endmodule

// File: rtl/sbx_host_fetch.sv
module sbx_host_fetch
  import sbx_pkg::*;
#(
  parameter int BUF_AW = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kick_i,
  input  logic              active_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              rd_i,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        buf_rdata_i,
  output logic              buf_rd_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              fill_o,
  output logic [15:0]       data_o,
  output logic              ready_o
);
  host_st_e    st_q;
  logic [7:0]  hi_q;
  logic [15:0] data_q;
  logic        ready_q, pend_q;
  logic        strobe;

  assign strobe     = rd_i || pend_q;
  assign buf_rd_o   = active_i && ((st_q == H_HI) || (st_q == H_LO));
  assign buf_addr_o = {addr_i[BUF_AW-1:1], (st_q == H_LO)};
  assign fill_o     = active_i && (st_q == H_FILL);
  assign data_o     = data_q;
  assign ready_o    = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= H_IDLE;
      hi_q    <= '0;
      data_q  <= '0;
      ready_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (start_i) ready_q <= 1'b0;
      case (st_q)
        H_IDLE: begin
          if (kick_i) begin
            st_q <= H_HI;
          end else if (strobe) begin
            pend_q <= 1'b0;
            if (end_i)         ready_q <= 1'b0;
            else if (active_i) st_q    <= H_HI;
          end
        end
        H_HI: begin
          if (!active_i) begin
            st_q   <= H_IDLE;
            pend_q <= 1'b0;
          end else begin
            st_q <= H_LO;
            if (rd_i) pend_q <= 1'b1;
          end
        end
        H_LO: begin
          if (!active_i) begin
            st_q   <= H_IDLE;
            pend_q <= 1'b0;
          end else begin
            hi_q <= buf_rdata_i;
            st_q <= H_FILL;
            if (rd_i) pend_q <= 1'b1;
          end
        end
        default: begin
          st_q <= H_IDLE;
          if (!active_i) begin
            pend_q <= 1'b0;
          end else begin
            data_q  <= {hi_q, buf_rdata_i};
            ready_q <= 1'b1;
            if (rd_i) pend_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sbx_dma_pace.sv
module sbx_dma_pace #(
  parameter int BYTE_CLKS = 16,
  parameter int GROUP     = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        hold_i,
  input  logic [15:0] cnt_i,
  output logic        rd_o,
  output logic        debit_o,
  output logic        done_o,
  output logic        wr_o
);
  localparam int PERIOD = BYTE_CLKS * GROUP;
  localparam int PACE_W = $clog2(PERIOD);
  localparam int LEFT_W = $clog2(GROUP + 1);
  localparam logic [PACE_W-1:0] PACE_TOP = PACE_W'(PERIOD - 1);
  localparam logic [15:0]       GROUP_W  = 16'(GROUP);

  logic [PACE_W-1:0] pace_q;
  logic [LEFT_W-1:0] left_q, grp_len;
  logic              final_q, wr_q;
  logic              last_grp, go, issue;

  always_comb begin
    last_grp = cnt_i[15] || (cnt_i < GROUP_W);
    if (cnt_i[15])     grp_len = '0;
    else if (last_grp) grp_len = LEFT_W'(cnt_i) + LEFT_W'(1);
    else               grp_len = LEFT_W'(GROUP);
    go    = run_i && !hold_i && (pace_q == PACE_TOP) && (left_q == '0) && !final_q;
    issue = run_i && !hold_i && (left_q != '0);
  end

  assign rd_o    = issue;
  assign debit_o = go && !last_grp;
  assign wr_o    = wr_q;
  assign done_o  = run_i && ((final_q && wr_q && (left_q == '0)) ||
                             (go && last_grp && (grp_len == '0)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pace_q  <= '0;
      left_q  <= '0;
      final_q <= 1'b0;
      wr_q    <= 1'b0;
    end else if (!run_i) begin
      pace_q  <= '0;
      left_q  <= '0;
      final_q <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= issue;
      if (!hold_i) begin
        if (pace_q != PACE_TOP) pace_q <= pace_q + PACE_W'(1);
        else if (go)            pace_q <= '0;
      end
      if (go) begin
        left_q  <= grp_len;
        final_q <= last_grp;
      end else if (issue) begin
        left_q <= left_q - LEFT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sbuf_xfer.sv
module sbuf_xfer
  import sbx_pkg::*;
#(
  parameter int BUF_AW    = 14,
  parameter int CNT_W     = 12,
  parameter int BYTE_CLKS = 16,
  parameter int GROUP     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              out_en_i,
  input  logic [2:0]        dest_i,
  input  logic              dst_owned_i,
  input  logic              addr_ld_i,
  input  logic [15:0]       addr_val_i,
  input  logic              cnt_ld_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              trig_i,
  input  logic              end_ack_i,
  input  logic              end_ie_i,
  input  logic              host_rd_i,
  output logic [15:0]       host_data_o,
  output logic              data_rdy_o,
  output logic              end_o,
  output logic              buf_rd_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              dma_wr_o,
  output logic [7:0]        dma_data_o,
  output logic [2:0]        dma_dest_o,
  output logic              busy_no,
  output logic              xen_no,
  output logic              tend_no,
  output logic              irq_o,
  output logic [15:0]       addr_o,
  output logic [15:0]       cnt_o
);
  logic       idle_q, end_q, tend_nq;
  logic [2:0] dest_q;
  logic       start, abort, finish, host_act, dma_run;
  logic       h_rd, h_fill, word_last;
  logic       d_rd, d_debit, d_done;
  logic [BUF_AW-1:0] h_addr;

  assign start    = trig_i && out_en_i && idle_q;
  assign abort    = !idle_q && !out_en_i;
  assign host_act = !idle_q && out_en_i && is_host(dest_q);
  assign dma_run  = !idle_q && out_en_i && is_dma(dest_q);
  assign finish   = (h_fill && word_last) || d_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b1;
      end_q  <= 1'b0;
      dest_q <= '0;
    end else if (start) begin
      idle_q <= 1'b0;
      end_q  <= 1'b0;
      dest_q <= dest_i;
    end else if (abort) begin
      idle_q <= 1'b1;
    end else if (finish) begin
      idle_q <= 1'b1;
      end_q  <= 1'b1;
    end
  end

  // transfer-end flag is only released by an explicit acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tend_nq <= 1'b1;
    else if (finish && !abort)   tend_nq <= 1'b0;
    else if (end_ack_i)          tend_nq <= 1'b1;
  end

  sbx_counters #(.CNT_W(CNT_W), .GROUP(GROUP)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_ld_i   (addr_ld_i),
    .addr_val_i  (addr_val_i),
    .cnt_ld_i    (cnt_ld_i),
    .cnt_val_i   (cnt_val_i),
    .word_step_i (h_fill),
    .byte_step_i (d_rd),
    .grp_debit_i (d_debit),
    .force_end_i (finish && !abort),
    .addr_o      (addr_o),
    .cnt_o       (cnt_o),
    .word_last_o (word_last)
  );

  sbx_host_fetch #(.BUF_AW(BUF_AW)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kick_i      (start && is_host(dest_i)),
    .active_i    (host_act),
    .start_i     (start),
    .end_i       (end_q),
    .rd_i        (host_rd_i),
    .addr_i      (addr_o),
    .buf_rdata_i (buf_rdata_i),
    .buf_rd_o    (h_rd),
    .buf_addr_o  (h_addr),
    .fill_o      (h_fill),
    .data_o      (host_data_o),
    .ready_o     (data_rdy_o)
  );

  sbx_dma_pace #(.BYTE_CLKS(BYTE_CLKS), .GROUP(GROUP)) u_dma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (dma_run),
    .hold_i  (dst_owned_i),
    .cnt_i   (cnt_o),
    .rd_o    (d_rd),
    .debit_o (d_debit),
    .done_o  (d_done),
    .wr_o    (dma_wr_o)
  );

  assign buf_rd_o   = h_rd || d_rd;
  assign buf_addr_o = d_rd ? addr_o[BUF_AW-1:0] : h_addr;
  assign dma_data_o = buf_rdata_i;
  assign dma_dest_o = dest_q;
  assign end_o      = end_q;
  assign busy_no    = idle_q;
  assign xen_no     = idle_q;
  assign tend_no    = tend_nq;
  assign irq_o      = !tend_nq && end_ie_i;
endmodule

// File: rtl/sbx_checker.sv
module sbx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        trig_i,
  input logic        out_en_i,
  input logic        dst_owned_i,
  input logic        busy_no,
  input logic        xen_no,
  input logic        tend_no,
  input logic        end_o,
  input logic        dma_wr_o,
  input logic [15:0] cnt_o,
  input logic [15:0] host_data_o
);
  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && out_en_i && xen_no |=> !xen_no && !busy_no && !end_o);

  assert_end_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_o) |-> (cnt_o == 16'hFFFF) && xen_no && busy_no && !tend_no);

  assert_wr_in_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_wr_o |-> !xen_no);

  assert_hold_no_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dst_owned_i) |-> !dma_wr_o);

  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xen_no && !out_en_i |=> xen_no && busy_no && !end_o);

  assert_latch_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o && !trig_i |=> $stable(host_data_o));
endmodule

bind sbuf_xfer sbx_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_i      (trig_i),
  .out_en_i    (out_en_i),
  .dst_owned_i (dst_owned_i),
  .busy_no     (busy_no),
  .xen_no      (xen_no),
  .tend_no     (tend_no),
  .end_o       (end_o),
  .dma_wr_o    (dma_wr_o),
  .cnt_o       (cnt_o),
  .host_data_o (host_data_o)
);

// File: tb/sim_sbuf_xfer.sv
module sim_sbuf_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        out_en = 1'b0, dst_owned = 1'b0, addr_ld = 1'b0, cnt_ld = 1'b0;
  logic        trig = 1'b0, end_ack = 1'b0, end_ie = 1'b1, host_rd = 1'b0;
  logic [2:0]  dest = 3'd0;
  logic [15:0] addr_val = '0;
  logic [11:0] cnt_val = '0;
  logic [15:0] host_data, addr_o, cnt_o;
  logic        data_rdy, end_o, buf_rd, dma_wr, busy_n, xen_n, tend_n, irq;
  logic [13:0] buf_addr;
  logic [7:0]  buf_rdata = '0, dma_data;
  logic [2:0]  dma_dest;

  int checks = 0, fails = 0, cyc = 0, nwr = 0;
  bit done = 1'b0;
  logic [7:0]  wr_data [0:63];
  int          wr_cyc  [0:63];
  logic [15:0] cnt_first = '0;

  always #2 clk = ~clk;

  sbuf_xfer u0 (
    .clk_i(clk), .rst_ni(rst_n), .out_en_i(out_en), .dest_i(dest),
    .dst_owned_i(dst_owned), .addr_ld_i(addr_ld), .addr_val_i(addr_val),
    .cnt_ld_i(cnt_ld), .cnt_val_i(cnt_val), .trig_i(trig), .end_ack_i(end_ack),
    .end_ie_i(end_ie), .host_rd_i(host_rd), .host_data_o(host_data),
    .data_rdy_o(data_rdy), .end_o(end_o), .buf_rd_o(buf_rd), .buf_addr_o(buf_addr),
    .buf_rdata_i(buf_rdata), .dma_wr_o(dma_wr), .dma_data_o(dma_data),
    .dma_dest_o(dma_dest), .busy_no(busy_n), .xen_no(xen_n), .tend_no(tend_n),
    .irq_o(irq), .addr_o(addr_o), .cnt_o(cnt_o)
  );

  function automatic logic [7:0] fb(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b10};
  endfunction

  // buffer model with one cycle of read latency
  always @(posedge clk) if (buf_rd) buf_rdata <= fb(buf_addr);
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (dma_wr) begin
      if (nwr == 0) cnt_first = cnt_o;
      if (nwr < 64) begin
        wr_data[nwr] = dma_data;
        wr_cyc[nwr]  = cyc;
      end
      nwr = nwr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setup(input logic [15:0] a, input logic [11:0] c, input logic [2:0] d);
    @(posedge clk); #1;
    addr_val = a; cnt_val = c; dest = d; addr_ld = 1'b1; cnt_ld = 1'b1;
    @(posedge clk); #1;
    addr_ld = 1'b0; cnt_ld = 1'b0; nwr = 0;
  endtask

  task automatic pulse_trig();
    @(posedge clk); #1 trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
  endtask

  task automatic pulse_rd();
    @(posedge clk); #1 host_rd = 1'b1;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic pulse_ack();
    @(posedge clk); #1 end_ack = 1'b1;
    @(posedge clk); #1 end_ack = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim && !end_o; i++) step(1);
  endtask

  task automatic t_reset();
    chk(busy_n == 1'b1, "R1", "busy_no", 32'(busy_n), 1);
    chk(xen_n == 1'b1, "R1", "xen_no", 32'(xen_n), 1);
    chk(tend_n == 1'b1, "R1", "tend_no", 32'(tend_n), 1);
    chk(end_o == 1'b0, "R1", "end_o", 32'(end_o), 0);
    chk(data_rdy == 1'b0, "R1", "data_rdy_o", 32'(data_rdy), 0);
    chk(irq == 1'b0, "R1", "irq_o", 32'(irq), 0);
  endtask

  task automatic t_no_enable();
    out_en = 1'b0;
    setup(16'h0040, 12'd3, 3'd2);
    pulse_trig();
    step(6);
    chk(xen_n == 1'b1, "R2", "xen_no without enable", 32'(xen_n), 1);
    chk(data_rdy == 1'b0, "R2", "no fetch without enable", 32'(data_rdy), 0);
  endtask

  task automatic t_host_basic();
    out_en = 1'b1;
    setup(16'h0101, 12'd3, 3'd2);
    pulse_trig();
    chk(xen_n == 1'b0 && busy_n == 1'b0, "R2", "started", {busy_n, xen_n}, 0);
    step(5);
    chk(data_rdy == 1'b1, "R3", "ready after first fetch", 32'(data_rdy), 1);
    chk(host_data == {fb(14'h100), fb(14'h101)}, "R3", "word 1 big-endian",
        host_data, {fb(14'h100), fb(14'h101)});
    chk(addr_o == 16'h0103, "R3", "address +2", addr_o, 16'h0103);
    chk(cnt_o == 16'd1, "R3", "count -2", cnt_o, 1);
    chk(end_o == 1'b0, "R6", "not ended yet", 32'(end_o), 0);
    pulse_rd();
    step(5);
    chk(host_data == {fb(14'h102), fb(14'h103)}, "R4", "word 2 after strobe",
        host_data, {fb(14'h102), fb(14'h103)});
    chk(end_o == 1'b1, "R6", "end_o set", 32'(end_o), 1);
    chk(cnt_o == 16'hFFFF, "R6", "count parked", cnt_o, 16'hFFFF);
    chk(xen_n == 1'b1 && busy_n == 1'b1, "R6", "enable released", {busy_n, xen_n}, 3);
    chk(tend_n == 1'b0 && irq == 1'b1, "R6", "tend low, irq", {tend_n, irq}, 1);
    chk(data_rdy == 1'b1, "R3", "ready on last word", 32'(data_rdy), 1);
    pulse_rd();
    step(2);
    chk(data_rdy == 1'b0, "R4", "strobe after end clears ready", 32'(data_rdy), 0);
    chk(host_data == {fb(14'h102), fb(14'h103)}, "R4", "latch unchanged after end",
        host_data, {fb(14'h102), fb(14'h103)});
    pulse_ack();
    chk(tend_n == 1'b1 && irq == 1'b0, "R6", "ack releases flag", {tend_n, irq}, 2);
  endtask

  task automatic t_host_mask();
    setup(16'hC000, 12'd1, 3'd3);
    pulse_trig();
    chk(end_o == 1'b0 && data_rdy == 1'b0, "R2", "start clears end/ready", {end_o, data_rdy}, 0);
    step(5);
    chk(host_data == {fb(14'h0000), fb(14'h0001)}, "R3", "14-bit buffer mask",
        host_data, {fb(14'h0000), fb(14'h0001)});
    chk(addr_o == 16'hC002, "R3", "full 16-bit address", addr_o, 16'hC002);
    chk(end_o == 1'b1 && cnt_o == 16'hFFFF, "R6", "one-word transfer ends", cnt_o, 16'hFFFF);
    pulse_ack();
  endtask

  task automatic t_host_held();
    setup(16'h0200, 12'd5, 3'd2);
    pulse_trig();
    step(5);
    @(posedge clk); #1 host_rd = 1'b1;
    @(posedge clk); #1 host_rd = 1'b1;
    @(posedge clk); #1 host_rd = 1'b0;
    step(12);
    chk(end_o == 1'b1, "R5", "held strobe reaches word 3", 32'(end_o), 1);
    chk(host_data == {fb(14'h204), fb(14'h205)}, "R5", "word 3 data",
        host_data, {fb(14'h204), fb(14'h205)});
    chk(data_rdy == 1'b1, "R5", "ready after replay", 32'(data_rdy), 1);
    pulse_ack();
  endtask

  task automatic t_dma_basic();
    int bad;
    setup(16'h3FFC, 12'd19, 3'd4);
    pulse_trig();
    wait_end(700);
    step(2);
    chk(nwr == 20, "R8", "bytes written", nwr, 20);
    bad = 0;
    for (int i = 0; i < 20; i++)
      if (wr_data[i] != fb(14'(16'h3FFC + 16'(i)))) bad++;
    chk(bad == 0, "R7", "byte order with wrap", bad, 0);
    chk(wr_cyc[8] - wr_cyc[0] == 128, "R7", "group spacing 1", wr_cyc[8] - wr_cyc[0], 128);
    chk(wr_cyc[16] - wr_cyc[8] == 128, "R7", "group spacing 2", wr_cyc[16] - wr_cyc[8], 128);
    chk(wr_cyc[7] - wr_cyc[0] == 7, "R7", "group back to back", wr_cyc[7] - wr_cyc[0], 7);
    chk(cnt_first == 16'd11, "R7", "count after first group", cnt_first, 11);
    chk(addr_o == 16'h4010, "R7", "address +1 per byte", addr_o, 16'h4010);
    chk(dma_dest == 3'd4, "R7", "dest code", dma_dest, 4);
    chk(end_o == 1'b1 && cnt_o == 16'hFFFF && xen_n == 1'b1, "R8", "end after short group",
        cnt_o, 16'hFFFF);
    pulse_ack();
  endtask

  task automatic t_dma_one_group();
    setup(16'h0080, 12'd7, 3'd7);
    pulse_trig();
    wait_end(400);
    step(2);
    chk(nwr == 8, "R8", "count 7 moves 8 bytes", nwr, 8);
    chk(end_o == 1'b1, "R8", "single group ends", 32'(end_o), 1);
    pulse_ack();
  endtask

  task automatic t_hold();
    int rel;
    dst_owned = 1'b1;
    setup(16'h0010, 12'd7, 3'd5);
    pulse_trig();
    step(400);
    chk(nwr == 0, "R9", "no bytes while owned", nwr, 0);
    chk(end_o == 1'b0 && xen_n == 1'b0, "R9", "still pending", {end_o, xen_n}, 0);
    chk(cnt_o == 16'd7, "R9", "count untouched", cnt_o, 7);
    rel = cyc;
    dst_owned = 1'b0;
    wait_end(400);
    step(2);
    chk(nwr == 8, "R9", "resumes after release", nwr, 8);
    chk((wr_cyc[0] - rel) >= 125 && (wr_cyc[0] - rel) <= 133, "R9", "pacing restarts",
        wr_cyc[0] - rel, 129);
    pulse_ack();
  endtask

  task automatic t_bad_code();
    setup(16'h0000, 12'd7, 3'd6);
    pulse_trig();
    step(300);
    chk(xen_n == 1'b0 && busy_n == 1'b0, "R10", "code 6 starts", {busy_n, xen_n}, 0);
    chk(nwr == 0 && data_rdy == 1'b0, "R10", "no data moved", nwr, 0);
    chk(end_o == 1'b0, "R10", "never ends", 32'(end_o), 0);
    out_en = 1'b0;
    step(2);
    chk(xen_n == 1'b1 && busy_n == 1'b1, "R11", "abort releases", {busy_n, xen_n}, 3);
    chk(end_o == 1'b0 && tend_n == 1'b1, "R11", "abort sets no end", {end_o, tend_n}, 1);
    out_en = 1'b1;
  endtask

  task automatic t_abort_dma();
    int n;
    setup(16'h0300, 12'd40, 3'd4);
    pulse_trig();
    for (int i = 0; i < 400 && nwr < 8; i++) step(1);
    out_en = 1'b0;
    step(2);
    n = nwr;
    chk(xen_n == 1'b1 && end_o == 1'b0, "R11", "dma abort", {xen_n, end_o}, 2);
    step(300);
    chk(nwr == n, "R11", "no writes after abort", nwr, n);
    out_en = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_no_enable();
    t_host_basic();
    t_host_mask();
    t_host_held();
    t_dma_basic();
    t_dma_one_group();
    t_hold();
    t_bad_code();
    t_abort_dma();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule